// File: doc/BRIEF.md
# Security Interrupt Status Aggregator

This block gathers the level-sensitive interrupt lines of a chip's security controllers into a few status words that the secure register window can read. It takes lines from the memory protection controllers, the peripheral protection controllers and the expansion master security controllers. Every source family sits at a fixed bit offset inside its status word, so firmware finds each controller at a known position.

The block also holds the masks that go with those status words. The peripheral-controller enable mask drives one enable line for each peripheral controller. The master-controller enable mask gates a single combined interrupt. An export mask drives one non-secure line for each master controller. Clearing is not a stored register. A write to a clear offset loads registered clear lines, and those lines hold their value until the next write to the same offset. Access goes through a plain 32-bit register port: one write strobe, a byte offset, write data, and read data that follows the offset combinationally.

Top module: `secint_aggregator`

## Requirements
- R1: The memory-controller status at offset 0x01C shows internal input n at bit n and expansion input n at bit n+16. Each bit equals the input level sampled at the previous clock edge.
- R2: The peripheral-controller status at 0x020 places controller index i as follows: indices 0 and 1 (internal) at bits 0 and 1, the next N_APB_EXP indices at bits 4 and up, and the last N_AHB_EXP indices at bits 20 and up. It has one cycle of latency.
- R3: A write to 0x028 stores only the valid peripheral bit positions (0x00F000F3 with default parameters). Enable output i then follows the stored bit at controller i's position.
- R4: A write to 0x020's clear companion at 0x024 loads each peripheral clear output from the status bit at that controller's position as it stands at the write. The outputs hold until the next such write, and 0x024 reads zero.
- R5: The master-controller status at 0x030 shows input n at bit n+16. The enable word at 0x038 is stored in full. The combined interrupt is high exactly when status AND enable is nonzero.
- R6: A write to 0x034 loads master clear line n from written bit n+16. The lines hold until the next such write, and 0x034 reads zero.
- R7: The export word at 0x0D0 is stored in full and reads back unchanged. Its bit n+16 drives non-secure output n.
- R8: The bridge enable at 0x048 keeps only bits [31:16]. The bridge status at 0x040 always reads zero, and a write to 0x044 has no effect and reads zero.
- R9: Writes to the status offsets 0x01C, 0x020 and 0x030 are ignored. Any offset not listed here reads zero and ignores writes.
- R10: A synchronous active-high reset clears every status, mask and clear register and drives all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| mpc_int_irq | input | N_MPC | Internal memory-controller interrupt levels |
| mpc_exp_irq | input | N_MPC_EXP | Expansion memory-controller interrupt levels |
| ppc_irq | input | 2+N_APB_EXP+N_AHB_EXP | Peripheral-controller interrupt levels, internal first, then APB expansion, then AHB expansion |
| ppc_irq_en | output | 2+N_APB_EXP+N_AHB_EXP | Per peripheral-controller interrupt enable |
| ppc_irq_clr | output | 2+N_APB_EXP+N_AHB_EXP | Per peripheral-controller interrupt clear level |
| msc_irq | input | N_MSC | Expansion master-controller interrupt levels |
| msc_clr | output | N_MSC | Per master-controller clear level |
| msc_ns | output | N_MSC | Per master-controller non-secure export |
| msc_irq_comb | output | 1 | Combined master-controller interrupt |

## Verification
The bench sweeps every input combination of the memory and peripheral controllers and checks the scattered bit positions. A design that packed the peripheral controllers contiguously, or put expansion lines at the wrong base, shows a shifted status word. It also sweeps every pairing of master status and enable. A combined interrupt that used OR in place of AND, or that ignored the enable, fails there. The clear outputs are checked after the source levels change with no new write. A design that let them track the status live, or kept the written value in place of the captured status, is caught by that check. Masked writes to the peripheral and bridge enables, ignored writes to status offsets, and a reset in mid-run show whether extra bits leak through or state survives.

// File: rtl/secint_pkg.sv
package secint_pkg;

    localparam int REG_W    = 32;
    localparam int ADDR_W   = 12;
    localparam int EXP_BASE = 16;

    localparam logic [ADDR_W-1:0] OFF_MPC_STAT = 12'h01C;
    localparam logic [ADDR_W-1:0] OFF_PPC_STAT = 12'h020;
    localparam logic [ADDR_W-1:0] OFF_PPC_CLR  = 12'h024;
    localparam logic [ADDR_W-1:0] OFF_PPC_EN   = 12'h028;
    localparam logic [ADDR_W-1:0] OFF_MSC_STAT = 12'h030;
    localparam logic [ADDR_W-1:0] OFF_MSC_CLR  = 12'h034;
    localparam logic [ADDR_W-1:0] OFF_MSC_EN   = 12'h038;
    localparam logic [ADDR_W-1:0] OFF_BRG_STAT = 12'h040;
    localparam logic [ADDR_W-1:0] OFF_BRG_CLR  = 12'h044;
    localparam logic [ADDR_W-1:0] OFF_BRG_EN   = 12'h048;
    localparam logic [ADDR_W-1:0] OFF_EXPORT   = 12'h0D0;

    localparam logic [REG_W-1:0] BRG_KEEP = 32'hFFFF_0000;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_MPC_STAT,
        SEL_PPC_STAT,
        SEL_PPC_EN,
        SEL_MSC_STAT,
        SEL_MSC_EN,
        SEL_BRG_EN,
        SEL_EXPORT
    } reg_sel_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  data;
    } reg_wr_t;

    // Readable offsets only; clear and bridge status fall to SEL_NONE (zero).
    function automatic reg_sel_e decode_read(logic [ADDR_W-1:0] a);
        case (a)
            OFF_MPC_STAT: return SEL_MPC_STAT;
            OFF_PPC_STAT: return SEL_PPC_STAT;
            OFF_PPC_EN:   return SEL_PPC_EN;
            OFF_MSC_STAT: return SEL_MSC_STAT;
            OFF_MSC_EN:   return SEL_MSC_EN;
            OFF_BRG_EN:   return SEL_BRG_EN;
            OFF_EXPORT:   return SEL_EXPORT;
            default:      return SEL_NONE;
        endcase
    endfunction

    // Status bit position of peripheral controller idx.
    function automatic int ppc_pos(int idx, int n_apb_exp);
        if (idx < 2)
            return idx;
        else if (idx < 2 + n_apb_exp)
            return 4 + (idx - 2);
        else
            return 20 + (idx - 2 - n_apb_exp);
    endfunction

    function automatic logic [REG_W-1:0] ppc_mask(int n_apb_exp, int n_ahb_exp);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < 2 + n_apb_exp + n_ahb_exp; i++)
            m[ppc_pos(i, n_apb_exp)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/secint_field_capture.sv
module secint_field_capture #(
    parameter int N   = 1,
    parameter int OFF = 0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [N-1:0] lvl,
    output logic [31:0]  word
);

    logic [N-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (rst)
            lvl_q <= '0;
        else
            lvl_q <= lvl;
    end

    for (genvar g = 0; g < 32; g++) begin : g_bit
        if (g >= OFF && g < OFF + N) begin : g_on
            assign word[g] = lvl_q[g-OFF];
        end else begin : g_off
            assign word[g] = 1'b0;
        end
    end

endmodule

// File: rtl/secint_ppc_ctrl.sv
module secint_ppc_ctrl
    import secint_pkg::*;
#(
    parameter  int N_APB_EXP = 4,
    parameter  int N_AHB_EXP = 4,
    localparam int N         = 2 + N_APB_EXP + N_AHB_EXP
) (
    input  logic             clk,
    input  logic             rst,
    input  reg_wr_t          wr,
    input  logic [REG_W-1:0] stat,
    output logic [REG_W-1:0] en_word,
    output logic [N-1:0]     en_o,
    output logic [N-1:0]     clr_o
);

    localparam logic [REG_W-1:0] MASK = ppc_mask(N_APB_EXP, N_AHB_EXP);

    logic [N-1:0] stat_pick;
    logic         wr_en, wr_clr;

    assign wr_en  = wr.we && (wr.addr == OFF_PPC_EN);
    assign wr_clr = wr.we && (wr.addr == OFF_PPC_CLR);

    for (genvar i = 0; i < N; i++) begin : g_ctl
        localparam int P = ppc_pos(i, N_APB_EXP);
        assign stat_pick[i] = stat[P];
        assign en_o[i]      = en_word[P];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_word <= '0;
            clr_o   <= '0;
        end else begin
            if (wr_en)
                en_word <= wr.data & MASK;
            if (wr_clr)
                clr_o <= stat_pick;
        end
    end

    assert_en_masked_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> en_word == ($past(wr.data) & MASK));

    assert_clr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_clr |=> $stable(clr_o));

endmodule

// File: rtl/secint_msc_ctrl.sv
module secint_msc_ctrl
    import secint_pkg::*;
#(
    parameter int N_MSC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  reg_wr_t          wr,
    input  logic [REG_W-1:0] stat,
    output logic [REG_W-1:0] en_word,
    output logic [REG_W-1:0] exp_word,
    output logic [N_MSC-1:0] clr_o,
    output logic [N_MSC-1:0] ns_o,
    output logic             irq_o
);

    logic wr_en, wr_clr, wr_exp;

    assign wr_en  = wr.we && (wr.addr == OFF_MSC_EN);
    assign wr_clr = wr.we && (wr.addr == OFF_MSC_CLR);
    assign wr_exp = wr.we && (wr.addr == OFF_EXPORT);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_word  <= '0;
            exp_word <= '0;
            clr_o    <= '0;
        end else begin
            if (wr_en)
                en_word <= wr.data;
            if (wr_exp)
                exp_word <= wr.data;
            if (wr_clr)
                clr_o <= wr.data[EXP_BASE +: N_MSC];
        end
    end

    assign ns_o  = exp_word[EXP_BASE +: N_MSC];
    assign irq_o = |(stat & en_word);

    assert_clr_load_R6: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> clr_o == $past(wr.data[EXP_BASE +: N_MSC]));

    assert_export_ns_R7: assert property (@(posedge clk) disable iff (rst)
        wr_exp |=> ns_o == $past(wr.data[EXP_BASE +: N_MSC]));

endmodule

// File: rtl/secint_aggregator.sv
module secint_aggregator
    import secint_pkg::*;
#(
    parameter  int N_MPC     = 2,
    parameter  int N_MPC_EXP = 4,
    parameter  int N_APB_EXP = 4,
    parameter  int N_AHB_EXP = 4,
    parameter  int N_MSC     = 4,
    localparam int N_PPC     = 2 + N_APB_EXP + N_AHB_EXP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [N_MPC-1:0]     mpc_int_irq,
    input  logic [N_MPC_EXP-1:0] mpc_exp_irq,
    input  logic [N_PPC-1:0]     ppc_irq,
    output logic [N_PPC-1:0]     ppc_irq_en,
    output logic [N_PPC-1:0]     ppc_irq_clr,
    input  logic [N_MSC-1:0]     msc_irq,
    output logic [N_MSC-1:0]     msc_clr,
    output logic [N_MSC-1:0]     msc_ns,
    output logic                 msc_irq_comb
);

    reg_wr_t          wr;
    logic [REG_W-1:0] mpc_lo_w, mpc_hi_w, mpc_stat;
    logic [REG_W-1:0] ppc_a_w, ppc_b_w, ppc_c_w, ppc_stat;
    logic [REG_W-1:0] msc_stat, ppc_en_word, msc_en_word, export_word;
    logic [REG_W-1:0] brg_en;
    reg_sel_e         rsel;

    assign wr = '{we: reg_we, addr: reg_addr, data: reg_wdata};

    secint_field_capture #(.N(N_MPC), .OFF(0)) u_mpc_lo (
        .clk(clk), .rst(rst), .lvl(mpc_int_irq), .word(mpc_lo_w));
    secint_field_capture #(.N(N_MPC_EXP), .OFF(EXP_BASE)) u_mpc_hi (
        .clk(clk), .rst(rst), .lvl(mpc_exp_irq), .word(mpc_hi_w));

    secint_field_capture #(.N(2), .OFF(0)) u_ppc_int (
        .clk(clk), .rst(rst), .lvl(ppc_irq[1:0]), .word(ppc_a_w));
    secint_field_capture #(.N(N_APB_EXP), .OFF(4)) u_ppc_apb (
        .clk(clk), .rst(rst), .lvl(ppc_irq[2 +: N_APB_EXP]), .word(ppc_b_w));
    secint_field_capture #(.N(N_AHB_EXP), .OFF(20)) u_ppc_ahb (
        .clk(clk), .rst(rst), .lvl(ppc_irq[2+N_APB_EXP +: N_AHB_EXP]), .word(ppc_c_w));

    secint_field_capture #(.N(N_MSC), .OFF(EXP_BASE)) u_msc (
        .clk(clk), .rst(rst), .lvl(msc_irq), .word(msc_stat));

    assign mpc_stat = mpc_lo_w | mpc_hi_w;
    assign ppc_stat = ppc_a_w | ppc_b_w | ppc_c_w;

    secint_ppc_ctrl #(.N_APB_EXP(N_APB_EXP), .N_AHB_EXP(N_AHB_EXP)) u_ppc (
        .clk(clk), .rst(rst), .wr(wr), .stat(ppc_stat),
        .en_word(ppc_en_word), .en_o(ppc_irq_en), .clr_o(ppc_irq_clr));

    secint_msc_ctrl #(.N_MSC(N_MSC)) u_msc_ctl (
        .clk(clk), .rst(rst), .wr(wr), .stat(msc_stat),
        .en_word(msc_en_word), .exp_word(export_word),
        .clr_o(msc_clr), .ns_o(msc_ns), .irq_o(msc_irq_comb));

    always_ff @(posedge clk) begin
        if (rst)
            brg_en <= '0;
        else if (reg_we && reg_addr == OFF_BRG_EN)
            brg_en <= reg_wdata & BRG_KEEP;
    end

    assign rsel = decode_read(reg_addr);

    always_comb begin
        case (rsel)
            SEL_MPC_STAT: reg_rdata = mpc_stat;
            SEL_PPC_STAT: reg_rdata = ppc_stat;
            SEL_PPC_EN:   reg_rdata = ppc_en_word;
            SEL_MSC_STAT: reg_rdata = msc_stat;
            SEL_MSC_EN:   reg_rdata = msc_en_word;
            SEL_BRG_EN:   reg_rdata = brg_en;
            SEL_EXPORT:   reg_rdata = export_word;
            default:      reg_rdata = '0;
        endcase
    end

    assert_mpc_follow_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && reg_addr == OFF_MPC_STAT)
            |-> reg_rdata[EXP_BASE +: N_MPC_EXP] == $past(mpc_exp_irq));

    assert_brg_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFF_BRG_STAT || reg_addr == OFF_BRG_CLR) |-> reg_rdata == '0);

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (ppc_irq_clr == '0 && msc_clr == '0 && msc_ns == '0 && !msc_irq_comb));

endmodule

// File: tb/secint_aggregator_tb.sv
`timescale 1ns/100ps
module secint_aggregator_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  mpc_int_irq = '0;
    logic [3:0]  mpc_exp_irq = '0;
    logic [9:0]  ppc_irq = '0;
    logic [9:0]  ppc_irq_en, ppc_irq_clr;
    logic [3:0]  msc_irq = '0;
    logic [3:0]  msc_clr, msc_ns;
    logic        msc_irq_comb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    secint_aggregator u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mpc_int_irq(mpc_int_irq), .mpc_exp_irq(mpc_exp_irq),
        .ppc_irq(ppc_irq), .ppc_irq_en(ppc_irq_en), .ppc_irq_clr(ppc_irq_clr),
        .msc_irq(msc_irq), .msc_clr(msc_clr), .msc_ns(msc_ns),
        .msc_irq_comb(msc_irq_comb));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic int pos_of(int i);
        if (i < 2) return i;
        if (i < 6) return i + 2;
        return i + 14;
    endfunction

    function automatic logic [31:0] ppc_word(logic [9:0] v);
        logic [31:0] w = '0;
        for (int i = 0; i < 10; i++) w[pos_of(i)] = v[i];
        return w;
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        rd(12'h01C, d); chk("R10 mpc stat", d, 0);
        rd(12'h028, d); chk("R10 ppc en", d, 0);
        rd(12'h038, d); chk("R10 msc en", d, 0);
        rd(12'h048, d); chk("R10 brg en", d, 0);
        rd(12'h0D0, d); chk("R10 export", d, 0);
        chk("R10 outputs", {ppc_irq_en, ppc_irq_clr, msc_clr, msc_ns, 3'b0, msc_irq_comb}, 0);

        // R1: memory controller status sweep
        for (int v = 0; v < 64; v++) begin
            @(negedge clk);
            mpc_int_irq = v[1:0]; mpc_exp_irq = v[5:2];
            @(negedge clk);
            rd(12'h01C, d);
            chk("R1 mpc stat", d, (32'(v[5:2]) << 16) | 32'(v[1:0]));
        end

        // R2: peripheral controller status sweep
        for (int v = 0; v < 1024; v++) begin
            @(negedge clk);
            ppc_irq = v[9:0];
            @(negedge clk);
            rd(12'h020, d);
            chk("R2 ppc stat", d, ppc_word(v[9:0]));
        end

        // R9: status offsets ignore writes; unmapped offsets read zero
        @(negedge clk); ppc_irq = 10'h2A5; mpc_int_irq = 2'b01; mpc_exp_irq = 4'h0;
        wr(12'h020, 32'hFFFF_FFFF);
        wr(12'h01C, 32'hFFFF_FFFF);
        wr(12'h030, 32'hFFFF_FFFF);
        rd(12'h020, d); chk("R9 ppc stat write ignored", d, ppc_word(10'h2A5));
        rd(12'h01C, d); chk("R9 mpc stat write ignored", d, 32'h1);
        rd(12'h030, d); chk("R9 msc stat write ignored", d, 0);
        wr(12'h004, 32'hDEAD_BEEF);
        rd(12'h004, d); chk("R9 unmapped", d, 0);
        rd(12'h100, d); chk("R9 unmapped", d, 0);

        // R3: enable masking and per-controller enable outputs
        wr(12'h028, 32'hFFFF_FFFF);
        rd(12'h028, d); chk("R3 en mask", d, 32'h00F0_00F3);
        chk("R3 en all", 32'(ppc_irq_en), 32'h3FF);
        for (int i = 0; i < 10; i++) begin
            wr(12'h028, 32'h1 << pos_of(i));
            chk("R3 en single", 32'(ppc_irq_en), 32'h1 << i);
        end
        wr(12'h028, 32'h000F_0F0C);
        chk("R3 en invalid bits", 32'(ppc_irq_en), 0);

        // R4: clear outputs capture status at the write and hold
        @(negedge clk); ppc_irq = 10'h155;
        settle();
        wr(12'h024, 32'h0);
        chk("R4 clr capture", 32'(ppc_irq_clr), 32'h155);
        rd(12'h024, d); chk("R4 clr reads zero", d, 0);
        @(negedge clk); ppc_irq = 10'h0AA;
        repeat (3) @(negedge clk);
        chk("R4 clr held", 32'(ppc_irq_clr), 32'h155);
        wr(12'h024, 32'hFFFF_FFFF);
        chk("R4 clr recapture", 32'(ppc_irq_clr), 32'h0AA);

        // R5: combined master interrupt over all status/enable pairs
        for (int s = 0; s < 16; s++) begin
            for (int e = 0; e < 16; e++) begin
                @(negedge clk); msc_irq = s[3:0];
                wr(12'h038, 32'(e) << 16);
                chk("R5 comb irq", 32'(msc_irq_comb), 32'((s & e) != 0));
                rd(12'h030, d); chk("R5 msc stat", d, 32'(s) << 16);
            end
        end
        wr(12'h038, 32'hFFFF_FFFF);
        rd(12'h038, d); chk("R5 en stored full", d, 32'hFFFF_FFFF);
        @(negedge clk); msc_irq = 4'h0;
        settle();
        chk("R5 comb low", 32'(msc_irq_comb), 0);

        // R6: master clear lines
        wr(12'h034, 32'h000A_0000);
        chk("R6 msc clr", 32'(msc_clr), 32'hA);
        rd(12'h034, d); chk("R6 clr reads zero", d, 0);
        repeat (3) @(negedge clk);
        chk("R6 msc clr held", 32'(msc_clr), 32'hA);
        wr(12'h034, 32'h0005_FFFF);
        chk("R6 msc clr reload", 32'(msc_clr), 32'h5);

        // R7: export register
        wr(12'h0D0, 32'h1234_5678);
        rd(12'h0D0, d); chk("R7 export readback", d, 32'h1234_5678);
        chk("R7 ns lines", 32'(msc_ns), 32'h4);
        wr(12'h0D0, 32'hFFF0_FFFF);
        chk("R7 ns lines zero", 32'(msc_ns), 0);

        // R8: bridge registers
        wr(12'h048, 32'hFFFF_FFFF);
        rd(12'h048, d); chk("R8 brg en keep", d, 32'hFFFF_0000);
        rd(12'h040, d); chk("R8 brg stat zero", d, 0);
        wr(12'h044, 32'hFFFF_FFFF);
        rd(12'h044, d); chk("R8 brg clr zero", d, 0);
        rd(12'h048, d); chk("R8 brg en unchanged", d, 32'hFFFF_0000);

        // R10: reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        ppc_irq = '0; msc_irq = '0; mpc_int_irq = '0; mpc_exp_irq = '0;
        repeat (2) @(negedge clk);
        rd(12'h028, d); chk("R10 ppc en after reset", d, 0);
        rd(12'h048, d); chk("R10 brg en after reset", d, 0);
        rd(12'h020, d); chk("R10 ppc stat after reset", d, 0);
        rd(12'h0D0, d); chk("R10 export after reset", d, 0);
        chk("R10 outputs after reset",
            {ppc_irq_en, ppc_irq_clr, msc_clr, msc_ns, 3'b0, msc_irq_comb}, 0);
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule